// File: doc/BRIEF.md
# Entropy Seed Register Access Unit

This block serves accesses to a read-write-only entropy seed control/status register in a RISC-V-style core. The decode stage presents one access per cycle: the CSR operation kind, a flag saying whether the source operand (register or immediate) is zero, the current privilege level and the virtualization flag. The unit also sees the crypto-entropy extension enable, two per-mode grant bits from the machine security configuration register, and a 16-bit entropy source. One cycle later it returns either a trap code or a 32-bit read value. That value holds a two-bit status in its top bits and, when fresh entropy was handed out, 16 random bits in its low half.

Legality is decided combinationally in the request cycle. The permission rules are checked in this order: the extension enable, the instruction form, then privilege and the grant bits. When a legal access finds a ready word, the unit pulses a consume strobe to the source in that same cycle, so that each word is handed out only once. No write data path exists. Whatever the instruction would write is never brought into the block, so it cannot change any state.

Top module: `seed_csr_unit`

## Requirements
- R1: After a synchronous reset, `rsp_valid` is 0, `rsp_exc` is 0 and `rsp_rdata` is 0. With no request, `ent_take` is 0.
- R2: When `ext_en` is 0, every access responds with `rsp_exc` = 1 (illegal instruction).
- R3: Operation codes are 0 = read-write, 1 = set, 2 = clear, 3 = reserved. Set or clear with `src_zero` = 1 is a read-only form and responds with illegal (1). Code 3 is also illegal. Read-write is legal even when `src_zero` = 1.
- R4: Privilege codes are 0 = user, 1 = supervisor, 2 = reserved, 3 = machine. In machine mode a legal form is always permitted (`rsp_exc` = 0).
- R5: A non-machine access with `virt` = 1 always traps. It responds with 2 (virtual instruction) when `grant_s` = 1 and with 1 otherwise.
- R6: Without virtualization, supervisor access needs `grant_s` = 1 and user access needs `grant_u` = 1. Reserved privilege is illegal.
- R7: A permitted access with `ent_valid` = 1, and no dead or self-test flag set, returns status 2'b10 (ES16) in bits 31:30, zeros in bits 29:16 and the entropy word in bits 15:0. `ent_take` is pulsed in the request cycle.
- R8: When `ent_dead` = 1 on a permitted access, the read returns status 2'b11 (DEAD) with zero entropy bits. There is no exception and no consume. Dead has priority over every other source flag.
- R9: A permitted access with no valid word returns status 2'b01 (WAIT) with zero entropy bits and no consume.
- R10: When `ent_bist` = 1 (and the source is not dead), a permitted access returns status 2'b00 (BIST) with zero entropy bits and no consume.
- R11: Each request produces exactly one response, one cycle later. A trapped access returns `rsp_rdata` = 0 and never consumes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access to the seed register is presented this cycle |
| csr_op | input | 2 | Operation kind: 0 read-write, 1 set, 2 clear, 3 reserved |
| src_zero | input | 1 | Source register is x0 or immediate is zero |
| priv | input | 2 | Privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| virt | input | 1 | Hart runs in a virtualized mode |
| ext_en | input | 1 | Crypto-entropy extension enabled |
| grant_s | input | 1 | Security-configuration grant bit for supervisor access |
| grant_u | input | 1 | Security-configuration grant bit for user access |
| ent_valid | input | 1 | Source holds a fresh 16-bit word |
| ent_dead | input | 1 | Source reports an unrecoverable failure |
| ent_bist | input | 1 | Source is running its built-in self-test |
| ent_data | input | 16 | Entropy word |
| ent_take | output | 1 | Consume strobe, same cycle as the granting request |
| rsp_valid | output | 1 | Response valid (one cycle after the request) |
| rsp_exc | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |
| rsp_rdata | output | 32 | Read value: status in 31:30, entropy in 15:0 |

## Verification
Permission and status rules can overlap, and those overlaps are the hardest cases to reach from the ports. Examples are a virtualized access whose supervisor grant changes the trap kind, a supervisor access where only the user grant is set, and a dead source that still reports a valid word. The stimulus walks through these combinations directly. Each one is issued back to back with ordinary reads, so a stale strobe or a leftover status would show up in the next response. Every read checks the consume strobe in its own request cycle. This catches a word that is handed out twice or dropped.

// File: rtl/seed_csr_pkg.sv
package seed_csr_pkg;
  typedef enum logic [1:0] {OP_RW = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_RSV = 2'd3} csr_op_e;
  typedef enum logic [1:0] {PL_USER = 2'd0, PL_SUPER = 2'd1, PL_RSV = 2'd2, PL_MACH = 2'd3} priv_e;
  typedef enum logic [1:0] {XC_NONE = 2'd0, XC_ILLEGAL = 2'd1, XC_VIRT = 2'd2, XC_UNUSED = 2'd3} exc_e;
  typedef enum logic [1:0] {SS_BIST = 2'd0, SS_WAIT = 2'd1, SS_ES16 = 2'd2, SS_DEAD = 2'd3} seed_stat_e;
endpackage

// File: rtl/seed_access_check.sv
module seed_access_check
  import seed_csr_pkg::*;
(
  input  logic       ext_en,
  input  logic [1:0] csr_op,
  input  logic       src_zero,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       grant_s,
  input  logic       grant_u,
  output logic [1:0] exc
);
  csr_op_e op_k;
  priv_e   pl_k;
  logic    form_ok;

  assign op_k = csr_op_e'(csr_op);
  assign pl_k = priv_e'(priv);

  // Only forms that really write are allowed; the reserved code never is.
  always_comb begin
    unique case (op_k)
      OP_RW:          form_ok = 1'b1;
      OP_SET, OP_CLR: form_ok = !src_zero;
      default:        form_ok = 1'b0;
    endcase
  end

  always_comb begin
    exc_e r;
    if (!ext_en || !form_ok) begin
      r = XC_ILLEGAL;
    end else if (pl_k == PL_MACH) begin
      r = XC_NONE;
    end else if (virt) begin
      r = grant_s ? XC_VIRT : XC_ILLEGAL;
    end else begin
      unique case (pl_k)
        PL_SUPER: r = grant_s ? XC_NONE : XC_ILLEGAL;
        PL_USER:  r = grant_u ? XC_NONE : XC_ILLEGAL;
        default:  r = XC_ILLEGAL;
      endcase
    end
    exc = r;
  end
endmodule

// File: rtl/seed_word_fmt.sv
module seed_word_fmt
  import seed_csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ENT_W = 16
) (
  input  logic             ent_valid,
  input  logic             ent_dead,
  input  logic             ent_bist,
  input  logic [ENT_W-1:0] ent_data,
  output logic [XLEN-1:0]  word,
  output logic             fresh
);
  localparam int PAD_W = XLEN - 2 - ENT_W;

  seed_stat_e       st;
  logic [ENT_W-1:0] bits;

  // Dead outranks self-test, which outranks a ready word.
  always_comb begin
    if (ent_dead)       st = SS_DEAD;
    else if (ent_bist)  st = SS_BIST;
    else if (ent_valid) st = SS_ES16;
    else                st = SS_WAIT;
  end

  assign fresh = (st == SS_ES16);
  assign bits  = fresh ? ent_data : '0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {st, {PAD_W{1'b0}}, bits};
    end else begin : g_nopad
      assign word = {st, bits};
    end
  endgenerate
endmodule

// File: rtl/seed_csr_unit.sv
module seed_csr_unit
  import seed_csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ENT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       csr_op,
  input  logic             src_zero,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             ext_en,
  input  logic             grant_s,
  input  logic             grant_u,
  input  logic             ent_valid,
  input  logic             ent_dead,
  input  logic             ent_bist,
  input  logic [ENT_W-1:0] ent_data,
  output logic             ent_take,
  output logic             rsp_valid,
  output logic [1:0]       rsp_exc,
  output logic [XLEN-1:0]  rsp_rdata
);
  logic [1:0]      exc_c;
  logic [XLEN-1:0] word_c;
  logic            fresh_c;
  logic            grant_c;

  seed_access_check u_chk_acc (
    .ext_en   (ext_en),
    .csr_op   (csr_op),
    .src_zero (src_zero),
    .priv     (priv),
    .virt     (virt),
    .grant_s  (grant_s),
    .grant_u  (grant_u),
    .exc      (exc_c)
  );

  seed_word_fmt #(.XLEN(XLEN), .ENT_W(ENT_W)) u_fmt (
    .ent_valid (ent_valid),
    .ent_dead  (ent_dead),
    .ent_bist  (ent_bist),
    .ent_data  (ent_data),
    .word      (word_c),
    .fresh     (fresh_c)
  );

  assign grant_c  = req_valid && (exc_c == XC_NONE);
  assign ent_take = grant_c && fresh_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_exc   <= XC_NONE;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_exc   <= req_valid ? exc_c : XC_NONE;
      rsp_rdata <= grant_c ? word_c : '0;
    end
  end
endmodule

// File: rtl/seed_csr_unit_chk.sv
module seed_csr_unit_chk #(
  parameter int XLEN  = 32,
  parameter int ENT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       csr_op,
  input logic             src_zero,
  input logic [1:0]       priv,
  input logic             virt,
  input logic             ext_en,
  input logic             ent_valid,
  input logic             ent_dead,
  input logic             ent_bist,
  input logic             ent_take,
  input logic             rsp_valid,
  input logic [1:0]       rsp_exc,
  input logic [XLEN-1:0]  rsp_rdata
);
  a_r11_one_rsp_per_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r2_ext_off_illegal: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ext_en) |=> (rsp_exc == 2'd1));
  a_r3_readonly_illegal: assert property (@(posedge clk) disable iff (rst)
    (req_valid && src_zero && (csr_op == 2'd1 || csr_op == 2'd2)) |=> (rsp_exc == 2'd1));
  a_r4_machine_ok: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ext_en && priv == 2'd3 && (csr_op == 2'd0 || (!src_zero && csr_op != 2'd3)))
      |=> (rsp_exc == 2'd0));
  a_r5_virt_traps: assert property (@(posedge clk) disable iff (rst)
    (req_valid && virt && priv != 2'd3) |=> (rsp_exc != 2'd0));
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[XLEN-3:ENT_W] == '0));
  a_r7_take_needs_word: assert property (@(posedge clk) disable iff (rst)
    ent_take |-> (req_valid && ent_valid && !ent_dead && !ent_bist));
  a_r7_es16_was_taken: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc == 2'd0 && rsp_rdata[XLEN-1:XLEN-2] == 2'b10) |-> $past(ent_take));
  a_r11_trap_zero_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc != 2'd0) |-> (rsp_rdata == '0));
endmodule

bind seed_csr_unit seed_csr_unit_chk #(.XLEN(XLEN), .ENT_W(ENT_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .csr_op    (csr_op),
  .src_zero  (src_zero),
  .priv      (priv),
  .virt      (virt),
  .ext_en    (ext_en),
  .ent_valid (ent_valid),
  .ent_dead  (ent_dead),
  .ent_bist  (ent_bist),
  .ent_take  (ent_take),
  .rsp_valid (rsp_valid),
  .rsp_exc   (rsp_exc),
  .rsp_rdata (rsp_rdata)
);

// File: tb/seed_csr_unit_bench.sv
`timescale 1ns/1ps
module seed_csr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic        src_zero = 1'b0;
  logic [1:0]  priv = 2'd3;
  logic        virt = 1'b0;
  logic        ext_en = 1'b1;
  logic        grant_s = 1'b0;
  logic        grant_u = 1'b0;
  logic        ent_valid = 1'b0;
  logic        ent_dead = 1'b0;
  logic        ent_bist = 1'b0;
  logic [15:0] ent_data = 16'h0;
  logic        ent_take;
  logic        rsp_valid;
  logic [1:0]  rsp_exc;
  logic [31:0] rsp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [1:0]  exc;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  seed_csr_unit u_seed_csr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .csr_op(csr_op), .src_zero(src_zero),
    .priv(priv), .virt(virt), .ext_en(ext_en), .grant_s(grant_s), .grant_u(grant_u),
    .ent_valid(ent_valid), .ent_dead(ent_dead), .ent_bist(ent_bist), .ent_data(ent_data),
    .ent_take(ent_take), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference rules written from the requirements.
  function automatic logic [1:0] ref_exc(bit en, logic [1:0] op, bit sz, logic [1:0] pl, bit vt, bit gs, bit gu);
    if (!en) return 2'd1;
    if (op == 2'd3 || (op != 2'd0 && sz)) return 2'd1;
    if (pl == 2'd3) return 2'd0;
    if (vt) return gs ? 2'd2 : 2'd1;
    if (pl == 2'd1) return gs ? 2'd0 : 2'd1;
    if (pl == 2'd0) return gu ? 2'd0 : 2'd1;
    return 2'd1;
  endfunction

  task automatic access(input bit en, input logic [1:0] op, input bit sz, input logic [1:0] pl,
                        input bit vt, input bit gs, input bit gu, input bit ev, input bit ed,
                        input bit eb, input logic [15:0] d, input string tag);
    logic [1:0]  e;
    logic [1:0]  st;
    logic [31:0] w;
    bit          tk;
    @(negedge clk);
    req_valid = 1'b1; ext_en = en; csr_op = op; src_zero = sz; priv = pl; virt = vt;
    grant_s = gs; grant_u = gu; ent_valid = ev; ent_dead = ed; ent_bist = eb; ent_data = d;
    e  = ref_exc(en, op, sz, pl, vt, gs, gu);
    st = ed ? 2'b11 : (eb ? 2'b00 : (ev ? 2'b10 : 2'b01));
    tk = (e == 2'd0) && (st == 2'b10);
    w  = (e != 2'd0) ? 32'h0 : {st, 14'h0, (st == 2'b10) ? d : 16'h0};
    #1;
    check(ent_take === tk, {tag, " take"}, {31'h0, ent_take}, {31'h0, tk});
    sb.push_back('{exc: e, data: w, tag: tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(ent_take === 1'b0, "R1 idle take", {31'h0, ent_take}, 32'h0);
    end
  endtask

  // Monitor: compares each response with the oldest expected item.
  always @(negedge clk) begin
    #2;
    if (!rst && rsp_valid === 1'b1) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11 unexpected response", {30'h0, rsp_exc}, 32'h0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(rsp_exc === x.exc, {x.tag, " exc"}, {30'h0, rsp_exc}, {30'h0, x.exc});
        check(rsp_rdata === x.data, {x.tag, " data"}, rsp_rdata, x.data);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(rsp_valid === 1'b0, "R1 reset valid", {31'h0, rsp_valid}, 32'h0);
    check(rsp_exc === 2'd0, "R1 reset exc", {30'h0, rsp_exc}, 32'h0);
    check(rsp_rdata === 32'h0, "R1 reset data", rsp_rdata, 32'h0);
    check(ent_take === 1'b0, "R1 reset take", {31'h0, ent_take}, 32'h0);

    //      en  op    sz  pl    vt gs gu ev ed eb data
    access(0, 2'd0, 0, 2'd3, 0, 1, 1, 1, 0, 0, 16'hA5A5, "R2 ext off M");
    access(0, 2'd0, 0, 2'd1, 0, 1, 1, 1, 0, 0, 16'h1111, "R2 ext off S");
    access(1, 2'd1, 1, 2'd3, 0, 1, 1, 1, 0, 0, 16'h2222, "R3 set x0");
    access(1, 2'd2, 1, 2'd3, 0, 1, 1, 1, 0, 0, 16'h3333, "R3 clr x0");
    access(1, 2'd3, 0, 2'd3, 0, 1, 1, 1, 0, 0, 16'h4444, "R3 reserved op");
    access(1, 2'd0, 1, 2'd3, 0, 0, 0, 1, 0, 0, 16'hBEEF, "R3 rw x0 legal");
    access(1, 2'd1, 0, 2'd3, 0, 0, 0, 1, 0, 0, 16'h0F0F, "R4 M set nz");
    access(1, 2'd2, 0, 2'd3, 0, 0, 0, 1, 0, 0, 16'hFFFF, "R4 M clr nz");
    access(1, 2'd0, 0, 2'd3, 0, 0, 0, 1, 0, 0, 16'h0001, "R7 M es16");
    access(1, 2'd0, 0, 2'd1, 1, 1, 1, 1, 0, 0, 16'h5555, "R5 VS grant");
    access(1, 2'd0, 0, 2'd0, 1, 1, 0, 1, 0, 0, 16'h6666, "R5 VU grant");
    access(1, 2'd0, 0, 2'd1, 1, 0, 1, 1, 0, 0, 16'h7777, "R5 VS nogrant");
    access(1, 2'd0, 0, 2'd1, 0, 1, 0, 1, 0, 0, 16'h8001, "R6 S grant");
    access(1, 2'd0, 0, 2'd1, 0, 0, 1, 1, 0, 0, 16'h8002, "R6 S only u");
    access(1, 2'd0, 0, 2'd0, 0, 0, 1, 1, 0, 0, 16'h8003, "R6 U grant");
    access(1, 2'd0, 0, 2'd0, 0, 1, 0, 1, 0, 0, 16'h8004, "R6 U only s");
    access(1, 2'd0, 0, 2'd2, 0, 1, 1, 1, 0, 0, 16'h8005, "R6 reserved priv");
    access(1, 2'd0, 0, 2'd3, 0, 0, 0, 1, 1, 0, 16'hDEAD, "R8 dead valid");
    access(1, 2'd0, 0, 2'd1, 0, 1, 0, 0, 1, 1, 16'h1234, "R8 dead bist");
    access(1, 2'd0, 0, 2'd3, 0, 0, 0, 0, 0, 0, 16'h9999, "R9 wait");
    access(1, 2'd0, 0, 2'd0, 0, 0, 1, 0, 0, 0, 16'hABCD, "R9 wait U");
    access(1, 2'd0, 0, 2'd3, 0, 0, 0, 1, 0, 1, 16'hC0DE, "R10 bist");
    access(1, 2'd0, 0, 2'd3, 0, 0, 0, 1, 0, 0, 16'h7E57, "R7 after bist");
    idle(2);
    access(1, 2'd1, 0, 2'd1, 0, 1, 0, 1, 0, 0, 16'hCAFE, "R11 after gap");
    access(1, 2'd0, 0, 2'd0, 0, 0, 0, 1, 0, 0, 16'hF00D, "R11 trap no take");
    idle(4);
    check(sb.size() == 0, "R11 responses drained", sb.size(), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule